// File: doc/BRIEF.md
# Link Delay Tuning Controller

This controller keeps an on-chip link clocked as fast as its wires allow. A variable delay cell, set by a 10-bit code, sits in front of a chain of three capture latches. The controller sweeps that code and reads back which latches took the new data value. From this it finds the two edges of the link's data-transition window. The distance between the edges is the timing slack. The controller then moves a 10-bit oscillator code, and an 8-bit divider code when the oscillator runs out of range, to raise or lower the link clock.

Each pass runs in a fixed order. First comes a downward sweep that finds the end of the transition. Next comes an upward sweep that finds its start. Then the slack is computed and one clock adjustment is made. After that the pass starts again. The delay cell, the oscillator and the divider are outside the block and appear here only as code outputs. Each sweep step holds its code for a settle time set by software. Upper and lower slack thresholds, and the number of in-range passes needed before the lock flag is raised, are also set by software.

Top module: `ldt_ctrl`

## Requirements
- R1: While rst_ni is low, and until the first clock edge after it is released, dly_code_o is 0, osc_code_o is 512, div_code_o is 1 and locked_o is 0.
- R2: Bit k of smp_i is 1 when latch k captured the new value. If bit 0 is set, the sample is too fast. Otherwise, if bit 1 is set, it is well tuned. Otherwise it is too slow.
- R3: Each pass begins with an end-of-transition sweep. The delay code is loaded with 1023 one cycle after the pass starts. Each code is held for settle_i+1 cycles, and the latches are sampled in the last of those cycles. The code then steps down by one. The sweep stops at the first code whose sample differs from the sweep's first sample, or at 0. That code is the end code.
- R4: A start-of-transition sweep follows. It loads the code 0 and steps up in the same way. It stops at the first differing code or at 1023. That code is the start code, and the delay code holds it until the next pass loads 1023.
- R5: The slack is the end code minus the start code. It is 0 when the start code is not below the end code.
- R6: Once per pass, slack greater than slack_hi_i decrements osc_code_o by one. Otherwise, slack less than slack_lo_i increments it. Slack equal to either threshold leaves it unchanged.
- R7: An increment at 1023 reloads the oscillator code to 512 and raises the divider code by one, stopping at 255. A decrement at 0 reloads 512 and lowers the divider code by one, stopping at 1.
- R8: Every too-slow sample taken during either sweep increments the oscillator code in that same cycle, following R7 at saturation.
- R9: locked_o rises at the adjustment that makes the count of consecutive in-range passes reach lock_need_i. It falls at the first adjustment whose slack is outside the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 3 | Capture latch flags: bit k set when latch k holds the new value |
| settle_i | input | 8 | Extra cycles each delay code is held before sampling |
| slack_hi_i | input | 10 | Slack above this speeds the clock up |
| slack_lo_i | input | 10 | Slack below this slows the clock down |
| lock_need_i | input | 8 | Consecutive in-range passes needed to lock |
| dly_code_o | output | 10 | Variable delay cell code |
| osc_code_o | output | 10 | Oscillator frequency code (lower is faster) |
| div_code_o | output | 8 | Clock divider code |
| locked_o | output | 1 | Slack has stayed inside the thresholds long enough |

## Verification
Oscillator saturation is the hardest case to reach. The code moves by only one step per pass, so reaching a divider change from slack alone would take hundreds of slow passes. The bench reaches it two ways. The first is a latch pattern that is too slow at every delay code: each sweep then hits its code limit and adds over a thousand increments, which pushes the divider up twice within one sweep. The second is a window almost as wide as the code range: each pass then takes about eight cycles, and the oscillator walks down to 0 and then hits the divider floor. A behavioural model of the pass sequence follows every cycle, so each sweep step, each too-slow bump and each lock change is compared as it happens.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

  typedef enum logic [2:0] {
    ST_MON_LD,
    ST_MON,
    ST_TUN_LD,
    ST_TUN,
    ST_SLACK,
    ST_ADJ
  } ldt_state_e;

  typedef enum logic [1:0] {
    CLS_FAST,
    CLS_TUNED,
    CLS_SLOW
  } ldt_cls_e;

  // earliest latch holding new data decides the class
  function automatic ldt_cls_e classify(input logic [2:0] smp);
    if (smp[0]) return CLS_FAST;
    if (smp[1]) return CLS_TUNED;
    return CLS_SLOW;
  endfunction

endpackage

// File: rtl/ldt_sweep.sv
module ldt_sweep #(
  parameter int unsigned DLY_W = 10,
  parameter int unsigned SET_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             up_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic [2:0]       smp_i,
  output logic [DLY_W-1:0] code_o,
  output logic             meas_o,
  output logic             done_o
);
  localparam logic [DLY_W-1:0] CODE_MAX = '1;
  localparam logic [DLY_W-1:0] CODE_ONE = DLY_W'(1);
  localparam logic [SET_W-1:0] CNT_ONE  = SET_W'(1);

  logic [DLY_W-1:0] code_q;
  logic [SET_W-1:0] cnt_q;
  logic [2:0]       ref_q;
  logic             first_q, act_q, up_q;
  logic             at_lim, diff;

  assign at_lim = up_q ? (code_q == CODE_MAX) : (code_q == '0);
  assign meas_o = act_q && (cnt_q >= settle_i);
  assign diff   = !first_q && (smp_i != ref_q);
  assign done_o = meas_o && (at_lim || diff);
  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      cnt_q   <= '0;
      ref_q   <= '0;
      first_q <= 1'b0;
      act_q   <= 1'b0;
      up_q    <= 1'b0;
    end else if (load_i) begin
      code_q  <= up_i ? '0 : CODE_MAX;
      up_q    <= up_i;
      cnt_q   <= '0;
      first_q <= 1'b1;
      act_q   <= 1'b1;
    end else if (act_q) begin
      if (!meas_o) begin
        cnt_q <= cnt_q + CNT_ONE;
      end else begin
        if (first_q) begin
          ref_q   <= smp_i;
          first_q <= 1'b0;
        end
        if (done_o) begin
          act_q <= 1'b0;
        end else begin
          code_q <= up_q ? code_q + CODE_ONE : code_q - CODE_ONE;
          cnt_q  <= '0;
        end
      end
    end
  end

  // R3
  code_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |->
      ($past(load_i) || code_q == $past(code_q) + CODE_ONE || code_q == $past(code_q) - CODE_ONE));

  // R3
  done_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !act_q || load_i);

endmodule

// File: rtl/ldt_clk_step.sv
module ldt_clk_step #(
  parameter int unsigned OSC_W = 10,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [OSC_W-1:0] osc_o,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [OSC_W-1:0] OSC_MAX = '1;
  localparam logic [OSC_W-1:0] OSC_MID = OSC_W'(1) << (OSC_W - 1);
  localparam logic [OSC_W-1:0] OSC_ONE = OSC_W'(1);
  localparam logic [DIV_W-1:0] DIV_MAX = '1;
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [OSC_W-1:0] osc_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= OSC_MID;
      div_q <= DIV_ONE;
    end else if (inc_i) begin
      if (osc_q == OSC_MAX) begin
        osc_q <= OSC_MID;
        if (div_q != DIV_MAX) div_q <= div_q + DIV_ONE;
      end else begin
        osc_q <= osc_q + OSC_ONE;
      end
    end else if (dec_i) begin
      if (osc_q == '0) begin
        osc_q <= OSC_MID;
        if (div_q != DIV_ONE) div_q <= div_q - DIV_ONE;
      end else begin
        osc_q <= osc_q - OSC_ONE;
      end
    end
  end

  assign osc_o = osc_q;
  assign div_o = div_q;

  // R6
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(inc_i && dec_i));

  // R7
  osc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_q != $past(osc_q)) |->
      (osc_q == OSC_MID || osc_q == $past(osc_q) + OSC_ONE || osc_q == $past(osc_q) - OSC_ONE));

  // R7
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) div_q != '0);

  // R7
  div_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q)) |-> (osc_q == OSC_MID));

endmodule

// File: rtl/ldt_lock.sv
module ldt_lock #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             locked_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             locked_q;

  assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (eval_i) begin
      if (hit_i) begin
        cnt_q    <= cnt_nxt;
        locked_q <= (cnt_nxt >= need_i);
      end else begin
        cnt_q    <= '0;
        locked_q <= 1'b0;
      end
    end
  end

  assign locked_o = locked_q;

  // R9
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(eval_i && hit_i));

  // R9
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !hit_i) |=> !locked_q);

endmodule

// File: rtl/ldt_ctrl.sv
module ldt_ctrl
  import ldt_pkg::*;
#(
  parameter int unsigned DLY_W = 10,
  parameter int unsigned OSC_W = 10,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SET_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       smp_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic [DLY_W-1:0] slack_hi_i,
  input  logic [DLY_W-1:0] slack_lo_i,
  input  logic [CNT_W-1:0] lock_need_i,
  output logic [DLY_W-1:0] dly_code_o,
  output logic [OSC_W-1:0] osc_code_o,
  output logic [DIV_W-1:0] div_code_o,
  output logic             locked_o
);
  ldt_state_e       state_q;
  logic [DLY_W-1:0] end_q, start_q, slack_q, code;
  logic             load, up, meas, done, in_search;
  logic             too_slow, over, under, adj, inc, dec;

  assign load      = (state_q == ST_MON_LD) || (state_q == ST_TUN_LD);
  assign up        = (state_q == ST_TUN_LD);
  assign in_search = (state_q == ST_MON) || (state_q == ST_TUN);
  assign too_slow  = in_search && meas && (classify(smp_i) == CLS_SLOW);
  assign adj       = (state_q == ST_ADJ);
  assign over      = slack_q > slack_hi_i;
  assign under     = !over && (slack_q < slack_lo_i);
  assign dec       = adj && over;
  assign inc       = too_slow || (adj && under);

  ldt_sweep #(.DLY_W(DLY_W), .SET_W(SET_W)) u_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .up_i     (up),
    .settle_i (settle_i),
    .smp_i    (smp_i),
    .code_o   (code),
    .meas_o   (meas),
    .done_o   (done)
  );

  ldt_clk_step #(.OSC_W(OSC_W), .DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc),
    .dec_i  (dec),
    .osc_o  (osc_code_o),
    .div_o  (div_code_o)
  );

  ldt_lock #(.CNT_W(CNT_W)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eval_i   (adj),
    .hit_i    (!over && !under),
    .need_i   (lock_need_i),
    .locked_o (locked_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MON_LD;
      end_q   <= '0;
      start_q <= '0;
      slack_q <= '0;
    end else begin
      unique case (state_q)
        ST_MON_LD: state_q <= ST_MON;
        ST_MON: if (done) begin
          end_q   <= code;
          state_q <= ST_TUN_LD;
        end
        ST_TUN_LD: state_q <= ST_TUN;
        ST_TUN: if (done) begin
          start_q <= code;
          state_q <= ST_SLACK;
        end
        ST_SLACK: begin
          slack_q <= (end_q > start_q) ? end_q - start_q : '0;
          state_q <= ST_ADJ;
        end
        ST_ADJ:  state_q <= ST_MON_LD;
        default: state_q <= ST_MON_LD;
      endcase
    end
  end

  assign dly_code_o = code;

  // R4
  tune_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TUN && $past(state_q == ST_TUN)) |-> (code >= $past(code)));

  // R3
  mon_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MON && $past(state_q == ST_MON)) |-> (code <= $past(code)));

  // R5
  slack_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADJ) |-> (slack_q <= end_q));

endmodule

// File: tb/sim_ldt_ctrl.sv
module sim_ldt_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] smp;
  logic [7:0] settle = 8'd0;
  logic [9:0] hi = 10'd500;
  logic [9:0] lo = 10'd100;
  logic [7:0] need = 8'd3;
  logic [9:0] dly, osc;
  logic [7:0] div;
  logic       locked;

  int ws = 300, we = 700;
  bit force_slow = 1'b0;
  int vectors = 0, miss = 0, cyc = 0, m_rounds = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  // reference model state
  int m_st, m_dly, m_cnt, m_ref, m_end, m_start, m_slack, m_osc, m_div, m_lc;
  bit m_first, m_act, m_up, m_locked;

  always #10 clk = ~clk;

  function automatic logic [2:0] link_pat(input int code, input int a, input int b, input bit slow);
    if (slow) return 3'b100;
    if (code >= a && code <= b) return 3'b110;
    return 3'b111;
  endfunction

  assign smp = link_pat(int'(dly), ws, we, force_slow);

  ldt_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_i       (smp),
    .settle_i    (settle),
    .slack_hi_i  (hi),
    .slack_lo_i  (lo),
    .lock_need_i (need),
    .dly_code_o  (dly),
    .osc_code_o  (osc),
    .div_code_o  (div),
    .locked_o    (locked)
  );

  always @(posedge clk) begin
    int  pat;
    bit  done, lim, inc, dec;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_dly = 0; m_cnt = 0; m_ref = 0; m_end = 0; m_start = 0; m_slack = 0;
      m_osc = 512; m_div = 1; m_lc = 0; m_first = 0; m_act = 0; m_up = 0; m_locked = 0;
    end else begin
      pat = int'(link_pat(m_dly, ws, we, force_slow));
      done = 0; inc = 0; dec = 0;
      case (m_st)
        0, 2: begin
          m_up = (m_st == 2); m_dly = m_up ? 0 : 1023;
          m_cnt = 0; m_first = 1; m_act = 1; m_st = m_st + 1;
        end
        1, 3: if (m_act) begin
          if (m_cnt < int'(settle)) m_cnt++;
          else begin
            lim = m_up ? (m_dly == 1023) : (m_dly == 0);
            if (pat[0] == 0 && pat[1] == 0) inc = 1;
            if (m_first) begin m_ref = pat; m_first = 0; done = lim; end
            else done = lim || (pat != m_ref);
            if (done) m_act = 0;
            else begin m_dly = m_dly + (m_up ? 1 : -1); m_cnt = 0; end
          end
          if (done) begin
            if (m_st == 1) begin m_end = m_dly; m_st = 2; end
            else begin m_start = m_dly; m_st = 4; end
          end
        end
        4: begin m_slack = (m_end > m_start) ? m_end - m_start : 0; m_st = 5; end
        default: begin
          if (m_slack > int'(hi)) dec = 1;
          else if (m_slack < int'(lo)) inc = 1;
          if (m_slack > int'(hi) || m_slack < int'(lo)) begin m_lc = 0; m_locked = 0; end
          else begin
            if (m_lc < 255) m_lc++;
            m_locked = (m_lc >= int'(need));
          end
          m_rounds++;
          m_st = 0;
        end
      endcase
      if (inc) begin
        if (m_osc == 1023) begin m_osc = 512; if (m_div < 255) m_div++; end
        else m_osc++;
      end else if (dec) begin
        if (m_osc == 0) begin m_osc = 512; if (m_div > 1) m_div--; end
        else m_osc--;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en && !finished) begin
      chk((m_st == 3 || m_st == 4) ? "R4" : "R3", "dly_code", int'(dly), m_dly);
      chk("R6", "osc_code", int'(osc), m_osc);
      chk("R7", "div_code", int'(div), m_div);
      chk("R9", "locked", int'(locked), int'(m_locked));
    end
  end

  task automatic report();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rounds(input int n);
    int tgt;
    tgt = m_rounds + n;
    wait (m_rounds >= tgt);
    @(negedge clk);
  endtask

  initial begin
    wait (cyc > 190000);
    if (!finished) begin
      miss++;
      vectors++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
      report();
    end
  end

  initial begin
    int o;
    cmp_en = 1'b1;
    // R1 reset values
    do_reset();
    chk("R1", "dly reset", int'(dly), 0);
    chk("R1", "osc reset", int'(osc), 512);
    chk("R1", "div reset", int'(div), 1);
    chk("R1", "locked reset", int'(locked), 0);

    // R2 R8: pattern 100 is too slow at every code, each sample bumps the oscillator
    force_slow = 1'b1; settle = 8'd0; hi = 10'd600; lo = 10'd100;
    do_reset();
    wait_rounds(1);
    chk("R8", "osc after slow pass", int'(osc), 513);
    chk("R2", "div after slow pass", int'(div), 5);

    // R6 R7: wide window, speed up until the divider floor
    force_slow = 1'b0; ws = 1; we = 1022; hi = 10'd500; lo = 10'd100;
    do_reset();
    wait_rounds(512);
    chk("R6", "osc walked to zero", int'(osc), 0);
    chk("R7", "div before floor", int'(div), 1);
    wait_rounds(1);
    chk("R7", "osc reload at floor", int'(osc), 512);
    chk("R7", "div held at floor", int'(div), 1);

    // R9 lock with settle cycles
    ws = 300; we = 700; hi = 10'd500; lo = 10'd200; need = 8'd3; settle = 8'd2;
    do_reset();
    wait_rounds(2);
    chk("R9", "not yet locked", int'(locked), 0);
    chk("R6", "osc in range", int'(osc), 512);
    chk("R4", "start code held", int'(dly), 300);
    wait_rounds(1);
    chk("R9", "locked after need", int'(locked), 1);
    ws = 500; we = 520;
    wait_rounds(1);
    chk("R9", "lock drops", int'(locked), 0);
    chk("R6", "narrow slows clock", int'(osc), 513);

    // R6 threshold equality
    ws = 300; we = 800; hi = 10'd500; lo = 10'd500; settle = 8'd0;
    o = int'(osc);
    wait_rounds(1);
    chk("R6", "slack equal thresholds", int'(osc), o);
    hi = 10'd499;
    wait_rounds(1);
    chk("R6", "slack above hi", int'(osc), o - 1);

    // R5 R4: empty window, both sweeps saturate
    ws = 2000; we = 2000; lo = 10'd100;
    o = int'(osc);
    wait_rounds(1);
    chk("R5", "clamped slack slows clock", int'(osc), o + 1);
    chk("R4", "start sweep saturates", int'(dly), 1023);

    repeat (4) @(negedge clk);
    report();
  end

endmodule